// File: doc/BRIEF.md
# Frame-Boundary Window Configuration Bank

This block keeps the geometry, buffer and format settings of a display controller's overlay windows in two copies. Software writes the shadow copy through a simple register port and can read it back at once. The display pipeline sees only the active copy, which is driven straight onto output ports and changes only at a frame boundary. This way a frame is never scanned out with a window that is only half configured.

Frames are marked by a one-cycle pulse on the vsync input. A copy from shadow to active happens only when software has armed it by writing the update-request bit. Even then, a window whose protect bit is set keeps its old active values. The request bit drops by itself once a transfer has moved at least one window. If every window was protected at that pulse, the request stays armed. Window 1 has a color-key register; window 0 has none. The bottom-right screen corner is computed from the position and the extent when the extent is written, and stored in inclusive form. A software-reset bit clears both copies at once.

Register map (word addresses): 0x00 control (bit 0 software reset, bit 1 update request; reads bit 1 = request pending); 0x01 protect mask (bit w protects window w). Window w occupies addresses 8·(w+1) + k, where k is one of:
- k=0: buffer base
- k=1: whole size, height[31:16] and width[15:0]
- k=2: read offset, y[31:16] and x[15:0]
- k=3: position, y[31:16] and x[15:0]
- k=4: extent. Writes take h[31:16] and w[15:0]; reads return the bottom-right corner as y[31:16] and x[15:0]
- k=5: mode, enable at bit 4 and format at [3:0]
- k=6: color key

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset every active output is zero, and every readable register reads 0.
- R2: A write changes the shadow copy; reading it back returns the new value in the next cycle. No active output changes in a cycle without a vsync pulse or a software reset.
- R3: Suppose the update request (control bit 1) is pending at a vsync pulse. Every unprotected window's active outputs then show the shadow values from before that edge, starting in the cycle after it. This includes a window that was protected earlier and has since been unprotected.
- R4: A window whose bit in the protect mask (address 0x01) is set keeps its active values across a vsync pulse. The other windows still take their shadow values at that pulse.
- R5: The request reads back as 1 in control bit 1 while it is pending. It clears after a vsync pulse that transferred at least one window. It stays set after a pulse at which every window was protected.
- R6: A vsync pulse while no request is pending leaves all active outputs unchanged.
- R7: Clearing a window's enable bit (mode bit 4) leaves its active enable at 1 until a vsync pulse with a pending request.
- R8: Writing the extent sets the bottom-right corner to position plus extent minus one, per axis, truncated to 16 bits. When the 17-bit sum of position and extent is 0, the corner is 0 instead.
- R9: Writes to window 0's color key (address 0x0E) are ignored: it reads 0 and its active key output stays 0. Window 1's key (address 0x16) is stored and transferred like any other field.
- R10: Writing control bit 0 clears both copies of every window, the protect mask and the pending request. It takes effect at the next edge, and the request bit in that same write is ignored.
- R11: If a request is written in the same cycle as a vsync pulse while none is pending, that pulse transfers nothing. The request is then pending for the following pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | DATA_W | Shadow value at rd_addr_i (combinational) |
| vsync_i | input | 1 | One-cycle frame-boundary pulse |
| act_base_o | output | NUM_WIN×DATA_W | Active buffer base per window |
| act_whole_w_o | output | NUM_WIN×COORD_W | Active whole width |
| act_whole_h_o | output | NUM_WIN×COORD_W | Active whole height |
| act_off_x_o | output | NUM_WIN×COORD_W | Active read offset X |
| act_off_y_o | output | NUM_WIN×COORD_W | Active read offset Y |
| act_pos_x_o | output | NUM_WIN×COORD_W | Active top-left X |
| act_pos_y_o | output | NUM_WIN×COORD_W | Active top-left Y |
| act_br_x_o | output | NUM_WIN×COORD_W | Active inclusive bottom-right X |
| act_br_y_o | output | NUM_WIN×COORD_W | Active inclusive bottom-right Y |
| act_fmt_o | output | NUM_WIN×FMT_W | Active format code |
| act_en_o | output | NUM_WIN | Active window enable |
| act_key_o | output | NUM_WIN×DATA_W | Active color key (window 0 always 0) |

## Verification
The transfer is exercised with vsync alone, with a request alone, and with each mix of protect bits. These runs separate the case where the gating is missing from the case where the request is cleared at the wrong time. Two cases test when the request is armed: a request written in the same cycle as a pulse, and a set of windows that are all protected. Both show whether the request is sampled before or after the edge. The corner arithmetic is tried at a zero sum, at a one-axis zero, and at a sum that wraps past 16 bits, which together reveal any off-by-one or any missing clamp. A reference model compares every active output and the read port on every cycle. That comparison catches a stray update in a cycle where no directed check happens to look.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  // global registers live on page 0
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_PROT = 3'd1;
  localparam int CTRL_RST_BIT = 0;
  localparam int CTRL_REQ_BIT = 1;
  localparam int MODE_EN_BIT  = 4;
  localparam int PAGE_SHIFT   = 3;

  // per-window register offsets inside a page
  typedef enum logic [2:0] {
    OFF_BASE  = 3'd0,
    OFF_WHOLE = 3'd1,
    OFF_OFFS  = 3'd2,
    OFF_POS   = 3'd3,
    OFF_EXT   = 3'd4,
    OFF_MODE  = 3'd5,
    OFF_KEY   = 3'd6
  } win_off_e;
endpackage

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int DATA_W  = 32,
  localparam int CTRL_W = (NUM_WIN > 2) ? NUM_WIN : 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [2:0]         wr_off_i,
  input  logic [CTRL_W-1:0]  wr_bits_i,
  input  logic               vsync_i,
  input  logic [2:0]         rd_off_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               clr_o,
  output logic [NUM_WIN-1:0] load_o,
  output logic               pending_o,
  output logic [NUM_WIN-1:0] protect_o
);
  logic req_set;
  logic xfer_any;

  assign clr_o    = wr_i && (wr_off_i == REG_CTRL) && wr_bits_i[CTRL_RST_BIT];
  assign req_set  = wr_i && (wr_off_i == REG_CTRL) && wr_bits_i[CTRL_REQ_BIT] && !clr_o;
  assign load_o   = {NUM_WIN{vsync_i && pending_o}} & ~protect_o;
  assign xfer_any = |load_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      protect_o <= '0;
    end else if (clr_o) begin
      pending_o <= 1'b0;
      protect_o <= '0;
    end else begin
      pending_o <= (pending_o && !xfer_any) || req_set;
      if (wr_i && (wr_off_i == REG_PROT)) protect_o <= wr_bits_i[NUM_WIN-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_off_i == REG_CTRL)      rd_data_o[CTRL_REQ_BIT] = pending_o;
    else if (rd_off_i == REG_PROT) rd_data_o[NUM_WIN-1:0]  = protect_o;
  end
endmodule

// File: rtl/shadow_win_slot.sv
module shadow_win_slot
  import shadow_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 16,
  parameter int FMT_W   = 4,
  parameter bit HAS_KEY = 1'b1,
  localparam int HALF   = DATA_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [2:0]         wr_off_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               load_i,
  input  logic [2:0]         rd_off_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [DATA_W-1:0]  act_base_o,
  output logic [COORD_W-1:0] act_whole_w_o,
  output logic [COORD_W-1:0] act_whole_h_o,
  output logic [COORD_W-1:0] act_off_x_o,
  output logic [COORD_W-1:0] act_off_y_o,
  output logic [COORD_W-1:0] act_pos_x_o,
  output logic [COORD_W-1:0] act_pos_y_o,
  output logic [COORD_W-1:0] act_br_x_o,
  output logic [COORD_W-1:0] act_br_y_o,
  output logic [FMT_W-1:0]   act_fmt_o,
  output logic               act_en_o,
  output logic [DATA_W-1:0]  act_key_o
);
  typedef struct packed {
    logic [DATA_W-1:0]  base;
    logic [COORD_W-1:0] ww, wh, ox, oy, px, py, bx, by;
    logic [FMT_W-1:0]   fmt;
    logic               en;
  } cfg_t;

  cfg_t sh_q, act_q;
  logic [DATA_W-1:0] sh_key;

  // inclusive far corner; a zero sum stays at zero
  function automatic logic [COORD_W-1:0] corner(input logic [COORD_W-1:0] start,
                                                input logic [COORD_W-1:0] size);
    logic [COORD_W:0] sum, less1;
    sum   = {1'b0, start} + {1'b0, size};
    less1 = sum - 1'b1;
    return (sum == '0) ? '0 : less1[COORD_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] pack2(input logic [COORD_W-1:0] lo,
                                              input logic [COORD_W-1:0] hi);
    logic [DATA_W-1:0] r;
    r = '0;
    r[0 +: COORD_W]    = lo;
    r[HALF +: COORD_W] = hi;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (clr_i) begin
      sh_q <= '0;
    end else if (wr_i) begin
      case (win_off_e'(wr_off_i))
        OFF_BASE:  sh_q.base <= wr_data_i;
        OFF_WHOLE: begin sh_q.ww <= wr_data_i[0 +: COORD_W]; sh_q.wh <= wr_data_i[HALF +: COORD_W]; end
        OFF_OFFS:  begin sh_q.ox <= wr_data_i[0 +: COORD_W]; sh_q.oy <= wr_data_i[HALF +: COORD_W]; end
        OFF_POS:   begin sh_q.px <= wr_data_i[0 +: COORD_W]; sh_q.py <= wr_data_i[HALF +: COORD_W]; end
        OFF_EXT: begin
          sh_q.bx <= corner(sh_q.px, wr_data_i[0 +: COORD_W]);
          sh_q.by <= corner(sh_q.py, wr_data_i[HALF +: COORD_W]);
        end
        OFF_MODE: begin
          sh_q.fmt <= wr_data_i[FMT_W-1:0];
          sh_q.en  <= wr_data_i[MODE_EN_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      act_q <= '0;
    else if (clr_i)   act_q <= '0;
    else if (load_i)  act_q <= sh_q;
  end

  generate
    if (HAS_KEY) begin : g_key
      logic [DATA_W-1:0] key_q, key_act_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          key_q     <= '0;
          key_act_q <= '0;
        end else if (clr_i) begin
          key_q     <= '0;
          key_act_q <= '0;
        end else begin
          if (wr_i && (win_off_e'(wr_off_i) == OFF_KEY)) key_q <= wr_data_i;
          if (load_i) key_act_q <= key_q;
        end
      end
      assign sh_key    = key_q;
      assign act_key_o = key_act_q;
    end else begin : g_nokey
      assign sh_key    = '0;
      assign act_key_o = '0;
    end
  endgenerate

  always_comb begin
    case (win_off_e'(rd_off_i))
      OFF_BASE:  rd_data_o = sh_q.base;
      OFF_WHOLE: rd_data_o = pack2(sh_q.ww, sh_q.wh);
      OFF_OFFS:  rd_data_o = pack2(sh_q.ox, sh_q.oy);
      OFF_POS:   rd_data_o = pack2(sh_q.px, sh_q.py);
      OFF_EXT:   rd_data_o = pack2(sh_q.bx, sh_q.by);
      OFF_MODE: begin
        rd_data_o = '0;
        rd_data_o[FMT_W-1:0]  = sh_q.fmt;
        rd_data_o[MODE_EN_BIT] = sh_q.en;
      end
      OFF_KEY:   rd_data_o = sh_key;
      default:   rd_data_o = '0;
    endcase
  end

  assign act_base_o    = act_q.base;
  assign act_whole_w_o = act_q.ww;
  assign act_whole_h_o = act_q.wh;
  assign act_off_x_o   = act_q.ox;
  assign act_off_y_o   = act_q.oy;
  assign act_pos_x_o   = act_q.px;
  assign act_pos_y_o   = act_q.py;
  assign act_br_x_o    = act_q.bx;
  assign act_br_y_o    = act_q.by;
  assign act_fmt_o     = act_q.fmt;
  assign act_en_o      = act_q.en;
endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int COORD_W = 16,
  parameter int FMT_W   = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  output logic [DATA_W-1:0]               rd_data_o,
  input  logic                            vsync_i,
  output logic [NUM_WIN-1:0][DATA_W-1:0]  act_base_o,
  output logic [NUM_WIN-1:0][COORD_W-1:0] act_whole_w_o,
  output logic [NUM_WIN-1:0][COORD_W-1:0] act_whole_h_o,
  output logic [NUM_WIN-1:0][COORD_W-1:0] act_off_x_o,
  output logic [NUM_WIN-1:0][COORD_W-1:0] act_off_y_o,
  output logic [NUM_WIN-1:0][COORD_W-1:0] act_pos_x_o,
  output logic [NUM_WIN-1:0][COORD_W-1:0] act_pos_y_o,
  output logic [NUM_WIN-1:0][COORD_W-1:0] act_br_x_o,
  output logic [NUM_WIN-1:0][COORD_W-1:0] act_br_y_o,
  output logic [NUM_WIN-1:0][FMT_W-1:0]   act_fmt_o,
  output logic [NUM_WIN-1:0]              act_en_o,
  output logic [NUM_WIN-1:0][DATA_W-1:0]  act_key_o
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int CTRL_W = (NUM_WIN > 2) ? NUM_WIN : 2;

  logic [PAGE_W-1:0]  wr_page, rd_page;
  logic               swrst_w;
  logic [NUM_WIN-1:0] load_w;
  logic               pending_w;
  logic [NUM_WIN-1:0] protect_w;
  logic [DATA_W-1:0]  glob_rd;
  logic [DATA_W-1:0]  slot_rd [NUM_WIN];

  assign wr_page = wr_addr_i[ADDR_W-1:PAGE_SHIFT];
  assign rd_page = rd_addr_i[ADDR_W-1:PAGE_SHIFT];

  shadow_bank_ctrl #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i && (wr_page == '0)),
    .wr_off_i  (wr_addr_i[PAGE_SHIFT-1:0]),
    .wr_bits_i (wr_data_i[CTRL_W-1:0]),
    .vsync_i   (vsync_i),
    .rd_off_i  (rd_addr_i[PAGE_SHIFT-1:0]),
    .rd_data_o (glob_rd),
    .clr_o     (swrst_w),
    .load_o    (load_w),
    .pending_o (pending_w),
    .protect_o (protect_w)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    shadow_win_slot #(
      .DATA_W(DATA_W), .COORD_W(COORD_W), .FMT_W(FMT_W), .HAS_KEY(w != 0)
    ) u_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .clr_i         (swrst_w),
      .wr_i          (wr_en_i && (wr_page == PAGE_W'(w + 1))),
      .wr_off_i      (wr_addr_i[PAGE_SHIFT-1:0]),
      .wr_data_i     (wr_data_i),
      .load_i        (load_w[w]),
      .rd_off_i      (rd_addr_i[PAGE_SHIFT-1:0]),
      .rd_data_o     (slot_rd[w]),
      .act_base_o    (act_base_o[w]),
      .act_whole_w_o (act_whole_w_o[w]),
      .act_whole_h_o (act_whole_h_o[w]),
      .act_off_x_o   (act_off_x_o[w]),
      .act_off_y_o   (act_off_y_o[w]),
      .act_pos_x_o   (act_pos_x_o[w]),
      .act_pos_y_o   (act_pos_y_o[w]),
      .act_br_x_o    (act_br_x_o[w]),
      .act_br_y_o    (act_br_y_o[w]),
      .act_fmt_o     (act_fmt_o[w]),
      .act_en_o      (act_en_o[w]),
      .act_key_o     (act_key_o[w])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_page == '0) rd_data_o = glob_rd;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rd_page == PAGE_W'(w + 1)) rd_data_o = slot_rd[w];
    end
  end
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           vsync_i,
  input logic                           wr_en_i,
  input logic [ADDR_W-1:0]              wr_addr_i,
  input logic                           req_bit_i,
  input logic                           swrst_w,
  input logic [NUM_WIN-1:0]             load_w,
  input logic                           pending_w,
  input logic [NUM_WIN-1:0]             protect_w,
  input logic [NUM_WIN-1:0][DATA_W-1:0] act_base_o,
  input logic [NUM_WIN-1:0]             act_en_o
);
  logic req_wr;
  assign req_wr = wr_en_i && (wr_addr_i == '0) && req_bit_i;

  AST_HOLD_NO_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vsync_i && !swrst_w) |=> ($stable(act_base_o) && $stable(act_en_o))); // R2

  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|load_w) && !req_wr && !swrst_w) |=> !pending_w); // R5

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_w && !(|load_w) && !swrst_w) |=> pending_w); // R5

  AST_SWRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_w |=> ((act_en_o == '0) && !pending_w && (protect_w == '0))); // R10

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
    AST_PROT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vsync_i && protect_w[w] && !swrst_w) |=> $stable(act_base_o[w])); // R4

    AST_EN_AT_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(act_en_o[w]) |-> $past(vsync_i)); // R7
  end
endmodule

bind vsync_shadow_bank shadow_bank_chk #(
  .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vsync_i    (vsync_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .req_bit_i  (wr_data_i[1]),
  .swrst_w    (swrst_w),
  .load_w     (load_w),
  .pending_w  (pending_w),
  .protect_w  (protect_w),
  .act_base_o (act_base_o),
  .act_en_o   (act_en_o)
);

// File: tb/tb_vsync_shadow_bank.sv
module tb_vsync_shadow_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic vsync = 1'b0;
  logic [1:0][31:0] a_base, a_key;
  logic [1:0][15:0] a_ww, a_wh, a_ox, a_oy, a_px, a_py, a_bx, a_by;
  logic [1:0][3:0] a_fmt;
  logic [1:0] a_en;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  vsync_shadow_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .vsync_i(vsync), .act_base_o(a_base), .act_whole_w_o(a_ww),
    .act_whole_h_o(a_wh), .act_off_x_o(a_ox), .act_off_y_o(a_oy),
    .act_pos_x_o(a_px), .act_pos_y_o(a_py), .act_br_x_o(a_bx),
    .act_br_y_o(a_by), .act_fmt_o(a_fmt), .act_en_o(a_en), .act_key_o(a_key)
  );

  // reference images: word k of window w as software sees it
  logic [31:0] sh [2][8];
  logic [31:0] ac [2][8];
  logic pend;
  logic [1:0] prot;

  function automatic logic [15:0] far_edge(input logic [15:0] s, input logic [15:0] z);
    int sum;
    sum = int'(s) + int'(z);
    if (sum == 0) return 16'h0;
    return 16'((sum - 1) % 65536);
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    int pg;
    pg = int'(a) / 8;
    if (a == 6'd0) return {30'd0, pend, 1'b0};
    if (a == 6'd1) return {30'd0, prot};
    if (pg == 1 || pg == 2) return sh[pg-1][int'(a) % 8];
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model, stepped on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) for (int k = 0; k < 8; k++) begin sh[w][k] = 0; ac[w][k] = 0; end
      pend = 0; prot = 0;
    end else if (wr_en && wr_addr == 6'd0 && wr_data[0]) begin
      for (int w = 0; w < 2; w++) for (int k = 0; k < 8; k++) begin sh[w][k] = 0; ac[w][k] = 0; end
      pend = 0; prot = 0;
    end else begin
      bit moved;
      moved = 0;
      if (vsync && pend) begin
        for (int w = 0; w < 2; w++) if (!prot[w]) begin
          for (int k = 0; k < 8; k++) ac[w][k] = sh[w][k];
          moved = 1;
        end
      end
      pend = (pend && !moved) || (wr_en && wr_addr == 6'd0 && wr_data[1]);
      if (wr_en) begin
        int pg, k;
        pg = int'(wr_addr) / 8;
        k = int'(wr_addr) % 8;
        if (wr_addr == 6'd1) prot = wr_data[1:0];
        else if (pg == 1 || pg == 2) begin
          case (k)
            0, 1, 2, 3: sh[pg-1][k] = wr_data;
            4: sh[pg-1][4] = {far_edge(sh[pg-1][3][31:16], wr_data[31:16]),
                              far_edge(sh[pg-1][3][15:0], wr_data[15:0])};
            5: sh[pg-1][5] = wr_data & 32'h1F;
            6: if (pg == 2) sh[1][6] = wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      for (int w = 0; w < 2; w++) begin
        check("R2/R3 base", a_base[w], ac[w][0]);
        check("R2/R3 whole", {a_wh[w], a_ww[w]}, ac[w][1]);
        check("R2/R3 offset", {a_oy[w], a_ox[w]}, ac[w][2]);
        check("R2/R3 pos", {a_py[w], a_px[w]}, ac[w][3]);
        check("R8 corner", {a_by[w], a_bx[w]}, ac[w][4]);
        check("R7 mode", {27'd0, a_en[w], a_fmt[w]}, ac[w][5]);
        check("R9 key", a_key[w], ac[w][6]);
      end
      check("R2 readback", rd_data, model_read(rd_addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
  endtask

  task automatic wr_pulse(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d; vsync = 1;
    @(negedge clk); wr_en = 0; vsync = 0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk); rd_addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 base0", a_base[0], 0);
    check("R1 en", {30'd0, a_en}, 0);
    rd("R1 ctrl", 6'd0, 0);
    rd("R1 w0 base", 6'd8, 0);

    wr(6'd8, 32'h1000_0000);
    wr(6'd11, 32'h000A_0014);
    wr(6'd12, 32'h0030_0040);
    wr(6'd13, 32'h13);
    check("R2 not live", a_base[0], 0);
    rd("R2 shadow", 6'd8, 32'h1000_0000);
    rd("R8 corner", 6'd12, 32'h0039_0053);

    pulse();
    check("R6 no request", a_base[0], 0);

    wr(6'd0, 32'h2);
    rd("R5 armed", 6'd0, 32'h2);
    pulse();
    check("R3 base", a_base[0], 32'h1000_0000);
    check("R8 br x", a_bx[0], 16'h53);
    check("R3 en", a_en[0], 1);
    check("R3 fmt", a_fmt[0], 3);
    rd("R5 cleared", 6'd0, 0);

    wr(6'd1, 32'h1);
    wr(6'd8, 32'h2000_0000);
    wr(6'd16, 32'h3000_0000);
    wr(6'd0, 32'h2);
    pulse();
    check("R4 protected", a_base[0], 32'h1000_0000);
    check("R4 other", a_base[1], 32'h3000_0000);
    rd("R5 cleared", 6'd0, 0);

    wr(6'd1, 32'h3);
    wr(6'd0, 32'h2);
    pulse();
    rd("R5 all protected", 6'd0, 32'h2);
    check("R4 w0 held", a_base[0], 32'h1000_0000);
    wr(6'd1, 32'h0);
    pulse();
    check("R3 unprotect", a_base[0], 32'h2000_0000);

    wr(6'd13, 32'h03);
    check("R7 still on", a_en[0], 1);
    pulse();
    check("R7 no request", a_en[0], 1);
    wr(6'd0, 32'h2);
    pulse();
    check("R7 off", a_en[0], 0);

    wr(6'd19, 32'h0);
    wr(6'd20, 32'h0);
    rd("R8 zero", 6'd20, 0);
    wr(6'd19, 32'h0000_0005);
    wr(6'd20, 32'h0);
    rd("R8 one axis", 6'd20, 32'h0000_0004);
    wr(6'd19, 32'hFFFF_FFFF);
    wr(6'd20, 32'h0001_0001);
    rd("R8 wrap", 6'd20, 32'hFFFF_FFFF);

    wr(6'd14, 32'hABCD_1234);
    rd("R9 w0 key", 6'd14, 0);
    wr(6'd22, 32'h55AA_55AA);
    rd("R9 w1 key", 6'd22, 32'h55AA_55AA);
    wr(6'd0, 32'h2);
    pulse();
    check("R9 w0 active key", a_key[0], 0);
    check("R9 w1 active key", a_key[1], 32'h55AA_55AA);

    wr(6'd16, 32'h4000_0000);
    wr_pulse(6'd0, 32'h2);
    check("R11 no transfer", a_base[1], 32'h3000_0000);
    rd("R11 armed", 6'd0, 32'h2);
    pulse();
    check("R11 next pulse", a_base[1], 32'h4000_0000);

    wr(6'd1, 32'h3);
    wr(6'd0, 32'h2);
    wr(6'd0, 32'h3);
    check("R10 active", a_base[1], 0);
    check("R10 en", {30'd0, a_en}, 0);
    rd("R10 shadow", 6'd16, 0);
    rd("R10 request", 6'd0, 0);
    rd("R10 protect", 6'd1, 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule